// File: doc/BRIEF.md
# Address-Driven Bit-Bang SPI Port

This block gives an 8-bit processor an SPI master port even though the processor can reach it only with memory reads. The top 2K of the 16-bit address space is an I/O window. A read that lands in the window, with RAM output enable asserted, raises an I/O select. When that select pulse ends, four low address bits of the last address in the pulse are latched into an output register. That register drives MOSI, SCK and two active-low slave selects. Software produces every SPI edge itself by choosing which address to read.

No data-bus buffer carries the serial input. MISO is folded into the RAM address instead: during a window access, address bit 10 going to the RAM is cleared whenever MISO is high. The top RAM page is pre-filled so that its lower half reads 0x01 and its upper half reads 0x00. As a result, a window read issued with bit 10 set (SCK high) returns MISO in bit 0 of the data. A behavioural image of that page is part of the block. Software may read the same address twice in a row, with output enable held, so that the longer address path has time to settle.

Top module: `spiwin_port`

## Requirements
- R1: `iosel_n` is low exactly when `cpu_addr[15:11]` are all ones and `oe_n` is low, and high otherwise.
- R2: While `rst_n` is low, and after it until the first window access ends, `mosi` = 0, `sck` = 0, `cs1_n` = 1 and `cs2_n` = 1.
- R3: The outputs change only at the first rising clock edge at which the window is no longer selected after a select pulse. The new values come from the last address seen during that pulse. While the pulse lasts, the outputs keep their previous values.
- R4: The latched values map as follows: address bit 7 gives `mosi`, address bit 10 gives `sck`, address bit 8 set drives `cs1_n` low, and address bit 9 set drives `cs2_n` low.
- R5: Reads outside the window, and window addresses presented with `oe_n` high, leave all four outputs unchanged.
- R6: `ram_addr` equals `cpu_addr`, except that `ram_addr[10]` is forced to 0 when the window is selected and `miso` is 1. Outside the window, `miso` has no effect on `ram_addr`.
- R7: When `oe_n` is low and `ram_addr[15:11]` are all ones, `rd_data` is 0x01 if `ram_addr[10]` is 0 and 0x00 if it is 1. In every other case it is 0x00. A window read with `cpu_addr[10]` = 1 therefore returns `miso` in bit 0.
- R8: Two back-to-back reads of the same window address, with `oe_n` held low, return the read data and latch that address once.
- R9: One mode-0 full-duplex byte, MSB first, can be bit-banged through window reads alone. The slave receives the MOSI byte, and bit 0 of the data read while SCK is high rebuilds the slave's byte.
- R10: A read of every address in a single select-held sweep that ends at 0xF8FF (bits 8 and 9 clear) leaves `cs1_n` = 1 and `cs2_n` = 1, with `sck` = 0 and `mosi` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the select tracking and the output register |
| rst_n | input | 1 | Asynchronous active-low startup reset |
| cpu_addr | input | 16 | Processor read address |
| oe_n | input | 1 | Active-low RAM output enable (a read is in progress) |
| miso | input | 1 | Serial data from the selected slave |
| rd_data | output | 8 | Data returned by the behavioural top-page RAM image |
| ram_addr | output | 16 | Address presented to RAM, with MISO folded into bit 10 |
| iosel_n | output | 1 | Active-low I/O window select |
| mosi | output | 1 | Serial data to the slaves |
| sck | output | 1 | Serial clock |
| cs1_n | output | 1 | Active-low select for slave 1 |
| cs2_n | output | 1 | Active-low select for slave 2 |

## Verification
The assertions take the address, `oe_n` and `miso` to be stable across each clock period, as on a bus that is sampled once per cycle. The latch assertion also assumes that the end of a select pulse is seen at a clock edge, so a select that is shorter than one cycle is outside what it covers. The bench changes every input at the falling clock edge and holds it for at least one full cycle. Between two accesses it raises `oe_n` for at least one cycle, so every pulse has a visible end. It changes `miso` only through the slave model, which reacts to the latched SCK, or while no slave is selected.

// File: rtl/spiwin_pkg.sv
package spiwin_pkg;

  typedef struct packed {
    logic sck;
    logic sel2;
    logic sel1;
    logic mosi;
  } spi_bits_t;

  function automatic logic top_hit(logic [31:0] a, int aw, int ww);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i >= aw - ww && i < aw) ok = ok & a[i];
    end
    return ok;
  endfunction

  function automatic spi_bits_t pick_bits(logic [31:0] a, int pm, int p1, int p2, int pk);
    spi_bits_t b;
    b.mosi = a[pm];
    b.sel1 = a[p1];
    b.sel2 = a[p2];
    b.sck  = a[pk];
    return b;
  endfunction

  function automatic logic subst_bit(logic abit, logic sel, logic sdi);
    return abit & ~(sel & sdi);
  endfunction

  function automatic logic page_bit(logic [31:0] a, int pos);
    return ~a[pos];
  endfunction

endpackage

// File: rtl/spiwin_decode.sv
module spiwin_decode
  import spiwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_W    = 5,
  parameter int MOSI_POS = 7,
  parameter int SEL1_POS = 8,
  parameter int SEL2_POS = 9,
  parameter int SCK_POS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  output logic              iosel,
  output logic              end_pulse,
  output spi_bits_t         cap
);

  logic iosel_q;

  assign iosel     = top_hit(32'(addr), ADDR_W, WIN_W) & ~oe_n;
  assign end_pulse = iosel_q & ~iosel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iosel_q <= 1'b0;
      cap     <= '0;
    end else begin
      iosel_q <= iosel;
      if (iosel) cap <= pick_bits(32'(addr), MOSI_POS, SEL1_POS, SEL2_POS, SCK_POS);
    end
  end

endmodule

// File: rtl/spiwin_outreg.sv
module spiwin_outreg
  import spiwin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      end_pulse,
  input  spi_bits_t cap,
  output logic      mosi,
  output logic      sck,
  output logic      cs1_n,
  output logic      cs2_n
);

  spi_bits_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (end_pulse) q <= cap;
  end

  assign mosi  = q.mosi;
  assign sck   = q.sck;
  assign cs1_n = ~q.sel1;
  assign cs2_n = ~q.sel2;

  // R2: reset clears every flip-flop, so the selects are released
  p_clear_r2: assert property (@(posedge clk) !rst_n |=> (q == '0));

  // R5: without the end of a pulse the register keeps its value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !end_pulse |=> $stable(q));

endmodule

// File: rtl/spiwin_swap.sv
module spiwin_swap
  import spiwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SWAP_POS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iosel,
  input  logic              sdi,
  output logic [ADDR_W-1:0] ram_addr
);

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    if (g == SWAP_POS) begin : g_sub
      assign ram_addr[g] = subst_bit(addr[g], iosel, sdi);
    end else begin : g_pass
      assign ram_addr[g] = addr[g];
    end
  end

  // R6: outside the window the address reaches RAM untouched
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iosel |-> (ram_addr == addr));

  // R6: a high serial input inside the window clears the folded bit
  p_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iosel && sdi) |-> !ram_addr[SWAP_POS]);

endmodule

// File: rtl/spiwin_page.sv
module spiwin_page
  import spiwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WIN_W    = 5,
  parameter int SWAP_POS = 10
) (
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data
);

  logic in_page;

  assign in_page = top_hit(32'(ram_addr), ADDR_W, WIN_W);

  always_comb begin
    rd_data = '0;
    if (!oe_n && in_page) rd_data = DATA_W'(page_bit(32'(ram_addr), SWAP_POS));
  end

endmodule

// File: rtl/spiwin_port.sv
module spiwin_port
  import spiwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WIN_W    = 5,
  parameter int MOSI_POS = 7,
  parameter int SEL1_POS = 8,
  parameter int SEL2_POS = 9,
  parameter int SCK_POS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              oe_n,
  input  logic              miso,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              iosel_n,
  output logic              mosi,
  output logic              sck,
  output logic              cs1_n,
  output logic              cs2_n
);

  logic      iosel;
  logic      end_pulse;
  spi_bits_t cap;

  spiwin_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .MOSI_POS(MOSI_POS),
    .SEL1_POS(SEL1_POS), .SEL2_POS(SEL2_POS), .SCK_POS(SCK_POS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .oe_n(oe_n),
    .iosel(iosel), .end_pulse(end_pulse), .cap(cap)
  );

  spiwin_outreg u_reg (
    .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .cap(cap),
    .mosi(mosi), .sck(sck), .cs1_n(cs1_n), .cs2_n(cs2_n)
  );

  spiwin_swap #(.ADDR_W(ADDR_W), .SWAP_POS(SCK_POS)) u_swap (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .iosel(iosel),
    .sdi(miso), .ram_addr(ram_addr)
  );

  spiwin_page #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .SWAP_POS(SCK_POS)
  ) u_page (
    .ram_addr(ram_addr), .oe_n(oe_n), .rd_data(rd_data)
  );

  assign iosel_n = ~iosel;

  // R7: a window read with the clock bit set returns the serial input
  p_sdi_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iosel_n && cpu_addr[SCK_POS]) |-> (rd_data == DATA_W'(miso)));

  // R7: a window read with the clock bit clear hits the 0x01 half
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iosel_n && !cpu_addr[SCK_POS]) |-> (rd_data == DATA_W'(1)));

endmodule

// File: tb/sim_spiwin_port.sv
`timescale 1ns/100ps
module sim_spiwin_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        oe_n = 1'b1;
  logic        miso_force = 1'b0;
  logic        slv_bit = 1'b0;
  logic        miso;
  logic [7:0]  rd_data;
  logic [15:0] ram_addr;
  logic        iosel_n, mosi, sck, cs1_n, cs2_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  logic [7:0] slv_load = 8'h00;
  logic [7:0] slv_tx = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  int exp_q[$];

  always #2.5 clk = ~clk;

  assign miso = cs1_n ? miso_force : slv_bit;

  spiwin_port u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .oe_n(oe_n), .miso(miso),
    .rd_data(rd_data), .ram_addr(ram_addr), .iosel_n(iosel_n),
    .mosi(mosi), .sck(sck), .cs1_n(cs1_n), .cs2_n(cs2_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pins packed as {cs2_n, cs1_n, sck, mosi}
  function automatic logic [3:0] expect_pins(input logic [15:0] a);
    return {~a[9], ~a[8], a[10], a[7]};
  endfunction

  // mode-0 slave model
  always @(negedge cs1_n) begin
    slv_tx  = slv_load;
    slv_bit = slv_load[7];
  end

  // monitor: pops the expected MOSI bit at every rising SCK
  always @(posedge sck) begin
    int e;
    if (mon_en && !cs1_n) begin
      slv_rx = {slv_rx[6:0], mosi};
      if (exp_q.size() == 0) chk("R9 unexpected sck edge", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R9 mosi bit at slave", {31'd0, mosi}, e);
      end
    end
  end

  always @(negedge sck) begin
    if (mon_en && !cs1_n) begin
      slv_tx  = {slv_tx[6:0], 1'b0};
      slv_bit = slv_tx[7];
    end
  end

  task automatic access(input logic [15:0] a, input int n, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    oe_n = 1'b0;
    repeat (n) @(negedge clk);
    d = rd_data;
    oe_n = 1'b1;
    cpu_addr = 16'h0123;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] txm, input logic [7:0] sbyte, output logic [7:0] got);
    logic [15:0] base;
    logic [7:0] d;
    slv_load = sbyte;
    mon_en = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      base = 16'hF900 | (txm[i] ? 16'h0080 : 16'h0000);
      access(base, 1, d);
      exp_q.push_back(int'(txm[i]));
      access(base | 16'h0400, 1, d);
      access(base | 16'h0400, 2, d);
      got[i] = d[0];
    end
    access(16'hF900, 1, d);
    access(16'hF800, 1, d);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] got;

    repeat (3) @(negedge clk);
    chk("R2 reset pins", {28'd0, cs2_n, cs1_n, sck, mosi}, 32'hC);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 pins after reset release", {28'd0, cs2_n, cs1_n, sck, mosi}, 32'hC);

    // R1 window decode
    cpu_addr = 16'hF800; oe_n = 1'b0; #1;
    chk("R1 F800 read selects", {31'd0, iosel_n}, 0);
    @(negedge clk); cpu_addr = 16'hF7FF; #1;
    chk("R1 F7FF outside", {31'd0, iosel_n}, 1);
    @(negedge clk); cpu_addr = 16'hFFFF; oe_n = 1'b1; #1;
    chk("R1 FFFF without oe", {31'd0, iosel_n}, 1);
    @(negedge clk); cpu_addr = 16'h7800; oe_n = 1'b0; #1;
    chk("R1 7800 outside", {31'd0, iosel_n}, 1);
    @(negedge clk); oe_n = 1'b1; cpu_addr = 16'h0000;
    @(negedge clk);

    // R6 / R7 address folding and page data (slaves deselected)
    cpu_addr = 16'hFC00; oe_n = 1'b0; miso_force = 1'b1; #1;
    chk("R6 fold clears bit10", {16'd0, ram_addr}, 32'hF800);
    chk("R7 miso 1 reads 01", {24'd0, rd_data}, 32'h01);
    @(negedge clk); miso_force = 1'b0; #1;
    chk("R6 miso 0 keeps bit10", {16'd0, ram_addr}, 32'hFC00);
    chk("R7 miso 0 reads 00", {24'd0, rd_data}, 32'h00);
    @(negedge clk); cpu_addr = 16'hF800; miso_force = 1'b1; #1;
    chk("R7 lower half reads 01", {24'd0, rd_data}, 32'h01);
    @(negedge clk); cpu_addr = 16'h1C00; #1;
    chk("R6 miso ignored outside window", {16'd0, ram_addr}, 32'h1C00);
    chk("R7 outside page reads 00", {24'd0, rd_data}, 32'h00);
    @(negedge clk); cpu_addr = 16'hFC00; oe_n = 1'b1; #1;
    chk("R6 miso ignored with oe high", {16'd0, ram_addr}, 32'hFC00);
    chk("R7 oe high reads 00", {24'd0, rd_data}, 32'h00);
    miso_force = 1'b0;
    access(16'hF800, 1, d);
    chk("R4 cleared by F800", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hF800)});

    // R3 capture at end of pulse, last address wins
    @(negedge clk); cpu_addr = 16'hFD80; oe_n = 1'b0;
    @(negedge clk);
    chk("R3 unchanged during pulse", {28'd0, cs2_n, cs1_n, sck, mosi}, 32'hC);
    cpu_addr = 16'hF880;
    @(negedge clk);
    chk("R3 unchanged later in pulse", {28'd0, cs2_n, cs1_n, sck, mosi}, 32'hC);
    oe_n = 1'b1; cpu_addr = 16'h0000;
    @(negedge clk);
    chk("R3 last address latched", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hF880)});

    // R4 bit mapping
    access(16'hF900, 1, d);
    chk("R4 bit8 to cs1_n", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hF900)});
    access(16'hFA00, 1, d);
    chk("R4 bit9 to cs2_n", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hFA00)});
    access(16'hFC00, 1, d);
    chk("R4 bit10 to sck", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hFC00)});
    access(16'hFF80, 1, d);
    chk("R4 all asserted", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hFF80)});

    // R5 hold during ordinary traffic
    access(16'h1234, 3, d);
    access(16'h07FF, 1, d);
    @(negedge clk); cpu_addr = 16'hF800; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 hold over other reads", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hFF80)});
    access(16'hF800, 1, d);

    // R8 double read at one address
    miso_force = 1'b1;
    access(16'hFC00, 2, d);
    chk("R8 second read data", {24'd0, d}, 32'h01);
    chk("R8 single latch", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hFC00)});
    miso_force = 1'b0;
    access(16'hF800, 1, d);

    // R9 full-duplex byte
    got = 8'h00;
    xfer(8'hC5, 8'h3C, got);
    chk("R9 miso byte rebuilt", {24'd0, got}, 32'h3C);
    chk("R9 mosi byte at slave", {24'd0, slv_rx}, 32'hC5);
    chk("R9 scoreboard drained", exp_q.size(), 0);
    chk("R9 select released", {31'd0, cs1_n}, 1);

    // R10 full sweep ending at F8FF
    access(16'hFF00, 1, d);
    chk("R10 selects asserted before sweep", {30'd0, cs2_n, cs1_n}, 0);
    @(negedge clk); oe_n = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      cpu_addr = 16'hF900 + 16'(i);
      @(negedge clk);
    end
    oe_n = 1'b1; cpu_addr = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    chk("R10 pins after sweep", {28'd0, cs2_n, cs1_n, sck, mosi}, {28'd0, expect_pins(16'hF8FF)});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule